// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Self-Timed Mode

This block handles refresh for a DRAM array. It samples the memory strobes on the system clock. When the row strobe falls and the strobe combination asks for a refresh, the block runs one refresh cycle of fixed length. The row it refreshes comes from an on-chip wrapping counter, and that counter steps forward once the cycle has finished. A column-before-row strobe order is treated as one more way to ask for the same internal refresh.

One strobe combination puts the block into a self-timed mode. In that mode an internal timer starts refresh cycles at a fixed interval and uses the same row counter. The mode ends when the row strobe goes high again. A refresh that is still running is allowed to finish, and a recovery interval follows before the block accepts the next command. While the block is unavailable, falling row strobes are ignored.

A monitor divides time into retention windows of fixed length. It counts the refreshes that complete in each window. If a window closes with too few of them, the monitor raises a flag that stays set until reset.

Top module: `rfc_refresh_ctrl`

## Requirements
- R1: When `row_strobe_n` is sampled falling and `refresh_sel_n` is low, the block runs a refresh regardless of the other pins. `refresh_req` pulses for one cycle, `busy` is high for exactly `REF_CYC` cycles, and `refresh_row` shows the row being refreshed.
- R2: At the end of every refresh, `refresh_row` steps up by one, wrapping modulo 2^`ROW_W`. It changes at no other time.
- R3: A row strobe fall with `col_strobe_n` low and `refresh_sel_n` high starts the same refresh as R1, unless the self-timed entry condition of R4 holds.
- R4: A row strobe fall with `col_strobe_n` low and `chip_sel_n`, `write_mode`, `refresh_sel_n` and `write_en_n` all high enters self-timed mode. `busy` goes high and no refresh starts at once.
- R5: In self-timed mode a refresh starts after every `SELF_PERIOD` idle cycles. Consecutive `refresh_req` pulses are `SELF_PERIOD + REF_CYC` cycles apart, and each one uses the next counter row.
- R6: Self-timed mode ends when `row_strobe_n` is sampled high. A refresh in progress completes, and then `busy` stays high for `RECOVER` more cycles. A row strobe fall while `busy` is high is ignored.
- R7: A row strobe fall with `col_strobe_n` and `refresh_sel_n` both high is a normal access. It starts no refresh and leaves the counter unchanged.
- R8: Each run of `WINDOW` cycles after reset is a retention window. If fewer than `MIN_REF` refreshes complete in a window, `violation` is set when the window closes, and it stays set until reset.
- R9: Reset (synchronous, active high) clears `refresh_row`, `refresh_req`, `busy` and `violation`.
- R10: `refresh_req` is never high for two cycles in a row, and it is only high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| chip_sel_n | input | 1 | Chip select, active low |
| write_mode | input | 1 | Write/read select, high for write |
| refresh_sel_n | input | 1 | Refresh select, active low |
| write_en_n | input | 1 | Write enable, active low |
| refresh_row | output | ROW_W | Row address of the current or next refresh |
| refresh_req | output | 1 | One-cycle pulse when a refresh starts |
| busy | output | 1 | High during refresh, self-timed mode and recovery |
| violation | output | 1 | Sticky retention-window violation flag |

## Verification
The properties take only one thing for granted: reset is asserted before the first clock edge. Beyond that they hold for any strobe sequence, because commands that arrive while the block is busy are dropped. The stimulus changes pins only on falling clock edges. It keeps the row strobe low for several cycles after each fall, so the decoder sees a clean edge. The self-timed periods, the exit and the recovery are run with small parameter overrides so that every interval can be counted exactly.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_REF,
    CMD_SELF
  } rfc_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_SELF,
    ST_SRUN,
    ST_RECOV
  } rfc_state_e;
endpackage

// File: rtl/rfc_strobe_decode.sv
module rfc_strobe_decode
  import rfc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     row_strobe_n,
  input  logic     col_strobe_n,
  input  logic     chip_sel_n,
  input  logic     write_mode,
  input  logic     refresh_sel_n,
  input  logic     write_en_n,
  output rfc_cmd_e cmd,
  output logic     row_hi
);
  logic     row_q;
  logic     fall;
  rfc_cmd_e cmd_nxt;

  // Priority: refresh select, then self-timed entry, then column-first refresh.
  always_comb begin
    fall    = row_q & ~row_strobe_n;
    cmd_nxt = CMD_NONE;
    if (fall) begin
      if (!refresh_sel_n)
        cmd_nxt = CMD_REF;
      else if (!col_strobe_n && chip_sel_n && write_mode && write_en_n)
        cmd_nxt = CMD_SELF;
      else if (!col_strobe_n)
        cmd_nxt = CMD_REF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= 1'b1;
      cmd   <= CMD_NONE;
    end else begin
      row_q <= row_strobe_n;
      cmd   <= cmd_nxt;
    end
  end

  assign row_hi = row_q;
endmodule

// File: rtl/rfc_row_counter.sv
module rfc_row_counter #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst)
      row <= '0;
    else if (inc)
      row <= row + 1'b1;
  end
endmodule

// File: rtl/rfc_window_monitor.sv
module rfc_window_monitor #(
  parameter int WINDOW  = 6_400_000,
  parameter int MIN_REF = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic done,
  output logic violation
);
  localparam int WW = $clog2(WINDOW);
  localparam int CW = $clog2(MIN_REF + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_REF);

  logic [WW-1:0] win;
  logic [CW-1:0] cnt;
  logic [CW:0]   total;

  assign total = {1'b0, cnt} + {{CW{1'b0}}, done};

  always_ff @(posedge clk) begin
    if (rst) begin
      win       <= '0;
      cnt       <= '0;
      violation <= 1'b0;
    end else if (win == WIN_LAST) begin
      win <= '0;
      cnt <= '0;
      if (total < (CW+1)'(MIN_REF))
        violation <= 1'b1;
    end else begin
      win <= win + 1'b1;
      if (done && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rfc_refresh_ctrl.sv
module rfc_refresh_ctrl
  import rfc_pkg::*;
#(
  parameter int ROW_W       = 10,
  parameter int MIN_REF     = 1024,
  parameter int WINDOW      = 6_400_000,
  parameter int REF_CYC     = 4,
  parameter int SELF_PERIOD = 6000,
  parameter int RECOVER     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_strobe_n,
  input  logic             col_strobe_n,
  input  logic             chip_sel_n,
  input  logic             write_mode,
  input  logic             refresh_sel_n,
  input  logic             write_en_n,
  output logic [ROW_W-1:0] refresh_row,
  output logic             refresh_req,
  output logic             busy,
  output logic             violation
);
  localparam int PH_MAX = (REF_CYC > RECOVER) ? REF_CYC : RECOVER;
  localparam int PHW    = $clog2(PH_MAX + 1);
  localparam int TW     = $clog2(SELF_PERIOD + 1);
  localparam logic [PHW-1:0] REF_LAST = PHW'(REF_CYC - 1);
  localparam logic [PHW-1:0] REC_LAST = PHW'(RECOVER - 1);
  localparam logic [TW-1:0]  PER_LAST = TW'(SELF_PERIOD - 1);

  rfc_cmd_e   cmd;
  logic       row_hi;
  rfc_state_e st;
  logic [PHW-1:0] ph;
  logic [TW-1:0]  tmr;
  logic           done;

  rfc_strobe_decode i_decode (
    .clk           (clk),
    .rst           (rst),
    .row_strobe_n  (row_strobe_n),
    .col_strobe_n  (col_strobe_n),
    .chip_sel_n    (chip_sel_n),
    .write_mode    (write_mode),
    .refresh_sel_n (refresh_sel_n),
    .write_en_n    (write_en_n),
    .cmd           (cmd),
    .row_hi        (row_hi)
  );

  assign done = ((st == ST_RUN) || (st == ST_SRUN)) && (ph == '0);

  rfc_row_counter #(.ROW_W(ROW_W)) i_rows (
    .clk (clk),
    .rst (rst),
    .inc (done),
    .row (refresh_row)
  );

  rfc_window_monitor #(.WINDOW(WINDOW), .MIN_REF(MIN_REF)) i_window (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .violation (violation)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      ph          <= '0;
      tmr         <= '0;
      busy        <= 1'b0;
      refresh_req <= 1'b0;
    end else begin
      refresh_req <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cmd == CMD_REF) begin
            st          <= ST_RUN;
            ph          <= REF_LAST;
            busy        <= 1'b1;
            refresh_req <= 1'b1;
          end else if (cmd == CMD_SELF) begin
            st   <= ST_SELF;
            tmr  <= '0;
            busy <= 1'b1;
          end
        end
        ST_RUN: begin
          if (ph == '0) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
          end else begin
            ph <= ph - 1'b1;
          end
        end
        ST_SELF: begin
          if (row_hi) begin
            st <= ST_RECOV;
            ph <= REC_LAST;
          end else if (tmr == PER_LAST) begin
            st          <= ST_SRUN;
            ph          <= REF_LAST;
            tmr         <= '0;
            refresh_req <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_SRUN: begin
          if (ph == '0) begin
            st <= row_hi ? ST_RECOV : ST_SELF;
            ph <= REC_LAST;
          end else begin
            ph <= ph - 1'b1;
          end
        end
        ST_RECOV: begin
          if (ph == '0) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
          end else begin
            ph <= ph - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfc_refresh_ctrl_chk.sv
module rfc_refresh_ctrl_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [ROW_W-1:0] refresh_row,
  input logic             refresh_req,
  input logic             busy,
  input logic             violation
);
  // R2: the row only ever advances by one
  a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(refresh_row) |-> refresh_row == ROW_W'($past(refresh_row) + 1'b1));

  // R2: the row advances only at the end of a refresh, while busy
  a_r2_row_in_busy: assert property (@(posedge clk) disable iff (rst)
    !$stable(refresh_row) |-> $past(busy));

  // R10: a request pulse lasts one cycle
  a_r10_req_single: assert property (@(posedge clk) disable iff (rst)
    refresh_req |=> !refresh_req);

  // R10: a request only appears while busy
  a_r10_req_in_busy: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> busy);

  // R8: the violation flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);
endmodule

bind rfc_refresh_ctrl rfc_refresh_ctrl_chk #(.ROW_W(ROW_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .refresh_row (refresh_row),
  .refresh_req (refresh_req),
  .busy        (busy),
  .violation   (violation)
);

// File: tb/test_rfc_refresh_ctrl.sv
module test_rfc_refresh_ctrl;
  localparam int CLK_PERIOD  = 10;
  localparam int ROW_W       = 4;
  localparam int MIN_REF     = 4;
  localparam int WINDOW      = 200;
  localparam int REF_CYC     = 3;
  localparam int SELF_PERIOD = 10;
  localparam int RECOVER     = 5;

  // Vector: [6:5] expected kind (0 none, 1 refresh, 2 self), [4:0] {col_n, cs_n, wm, rsel_n, we_n}
  localparam int NVEC = 8;
  localparam logic [6:0] VEC [NVEC] = '{
    {2'd1, 5'b10101},  // R1 refresh select
    {2'd1, 5'b01101},  // R1 refresh select wins over self entry
    {2'd1, 5'b00111},  // R3 column-first, chip selected
    {2'd2, 5'b01111},  // R4 self entry
    {2'd0, 5'b11111},  // R7 normal access
    {2'd1, 5'b01110},  // R3 column-first, write enable low
    {2'd0, 5'b10010},  // R7 normal write
    {2'd1, 5'b01011}   // R3 column-first, read mode
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic row_n = 1'b1, col_n = 1'b1, cs_n = 1'b0, wm = 1'b1, rsel_n = 1'b1, we_n = 1'b1;
  logic [ROW_W-1:0] refresh_row;
  logic refresh_req, busy, violation;

  int runs = 0;
  int fails = 0;
  int cyc = 0;
  logic [ROW_W-1:0] exp_row = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  rfc_refresh_ctrl #(
    .ROW_W(ROW_W), .MIN_REF(MIN_REF), .WINDOW(WINDOW),
    .REF_CYC(REF_CYC), .SELF_PERIOD(SELF_PERIOD), .RECOVER(RECOVER)
  ) i_rfc_refresh_ctrl (
    .clk(clk), .rst(rst), .row_strobe_n(row_n), .col_strobe_n(col_n),
    .chip_sel_n(cs_n), .write_mode(wm), .refresh_sel_n(rsel_n), .write_en_n(we_n),
    .refresh_row(refresh_row), .refresh_req(refresh_req), .busy(busy), .violation(violation)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_pins();
    col_n = 1'b1; cs_n = 1'b0; wm = 1'b1; rsel_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic run_vec(input logic [6:0] v);
    bit saw = 0;
    int req_row = 0;
    @(negedge clk);
    {col_n, cs_n, wm, rsel_n, we_n} = v[4:0];
    row_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (refresh_req) begin saw = 1; req_row = int'(refresh_row); end
    end
    if (v[6:5] == 2'd1) begin
      check(saw, "R1/R3 request", int'(saw), 1);
      check(req_row == int'(exp_row), "R1 row", req_row, int'(exp_row));
      exp_row = exp_row + 1'b1;
      check(refresh_row == exp_row, "R2 step", int'(refresh_row), int'(exp_row));
    end else if (v[6:5] == 2'd2) begin
      check(!saw && busy, "R4 self entry", {30'd0, saw, busy}, 1);
    end else begin
      check(!saw && !busy, "R7 no refresh", {30'd0, saw, busy}, 0);
      check(refresh_row == exp_row, "R7 row kept", int'(refresh_row), int'(exp_row));
    end
    row_n = 1'b1;
    idle_pins();
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
  endtask

  task automatic enter_self();
    @(negedge clk);
    {col_n, cs_n, wm, rsel_n, we_n} = 5'b01111;
    row_n = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int n;
    bit saw;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(refresh_row == '0 && !busy && !refresh_req && !violation, "R9 reset state",
          {refresh_row, busy, refresh_req, violation}, 0);

    // Vector table
    for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

    // R8 first window met, second window empty
    while (cyc < WINDOW + 10) @(negedge clk);
    check(!violation, "R8 window met", int'(violation), 0);
    while (cyc < 2 * WINDOW + 20) @(negedge clk);
    check(violation, "R8 window missed", int'(violation), 1);

    // R5 periodic refresh in self-timed mode
    enter_self();
    n = 0;
    do begin @(negedge clk); n++; end while (!refresh_req && n < 40);
    check(refresh_req && refresh_row == exp_row, "R5 first self refresh", int'(refresh_row), int'(exp_row));
    exp_row = exp_row + 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!refresh_req && n < 40);
    check(n == SELF_PERIOD + REF_CYC, "R5 interval", n, SELF_PERIOD + REF_CYC);
    check(refresh_row == exp_row, "R5 next row", int'(refresh_row), int'(exp_row));
    exp_row = exp_row + 1'b1;

    // R6 exit during a self refresh: it completes, then recovery
    row_n = 1'b1;
    idle_pins();
    n = 0;
    @(negedge clk);
    while (busy && n < 40) begin n++; @(negedge clk); end
    check(n == REF_CYC + RECOVER - 1, "R6 exit busy length", n, REF_CYC + RECOVER - 1);
    check(refresh_row == exp_row, "R6 refresh finished", int'(refresh_row), int'(exp_row));

    // R6 fall during recovery is ignored
    enter_self();
    repeat (3) @(negedge clk);
    row_n = 1'b1;
    idle_pins();
    n = 0;
    saw = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 1) begin row_n = 1'b0; rsel_n = 1'b0; end
      if (busy) n++;
      if (refresh_req) saw = 1;
    end
    check(n == RECOVER + 1, "R6 recovery length", n, RECOVER + 1);
    check(!saw, "R6 fall ignored", int'(saw), 0);
    check(refresh_row == exp_row, "R6 row kept", int'(refresh_row), int'(exp_row));
    row_n = 1'b1;
    idle_pins();
    repeat (3) @(negedge clk);

    // R2 wrap of the row counter
    for (int k = 0; k < 20; k++) run_vec({2'd1, 5'b10101});
    check(refresh_row == exp_row, "R2 wrap", int'(refresh_row), int'(exp_row));
    check(violation, "R8 sticky", int'(violation), 1);

    // R9 reset clears everything
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(refresh_row == '0 && !busy && !refresh_req && !violation, "R9 re-reset",
          {refresh_row, busy, refresh_req, violation}, 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule